// File: doc/BRIEF.md
# Two-Pin Power-Down Freeze Wrapper

This block sits between a group of logic pins and the small amount of registered and combinational logic that serves them. Two asynchronous power-down pins are ORed together and gated by a static enable bit. The result passes through a clock-domain synchroniser. Once the synchronised request is active, the block stops accepting pin activity. Every internal register, every output level and every output-enable bit keeps the value it had when the freeze began. A channel whose driver was off stays in high impedance for the whole freeze. A standby flag reports the frozen condition. When both pins go low again, the block leaves the freeze through the same synchroniser and continues from the values it held.

Each channel captures its input pin into a hold register. It passes that value on to a state register, so it offers both a registered view and a combinational change-detect view (hold XOR state). A per-channel select input chooses which of the two views drives the pin. An optional keeper stage stands in for real pin keepers. A channel whose drive-valid bit is low reads the last level it saw while driven, and that remembered level is itself frozen during standby.

Top module: `pdh_freeze_unit`

## Requirements
- R1: While reset is held, and at its release, pin_out, pin_oe and standby are all zero.
- R2: With out_sel[i]=1, pin_out[i] shows the channel input two clock edges after it is applied. With out_sel[i]=0, it shows the XOR of the input captured one edge ago and the value captured two edges ago, so it reads 0 once the input has been steady for two edges.
- R3: pin_oe[i] follows oe_req[i] one clock edge after it is applied, outside standby.
- R4: The power-down request is pd_en AND (pd_a OR pd_b). standby rises on the second clock edge after the request becomes active, and not on the first.
- R5: With pd_en=0, the pd_a and pd_b pins have no effect: standby stays 0 and data keeps flowing.
- R6: While standby is 1, changes on din, din_drv and oe_req are ignored. pin_out and pin_oe hold their values, and channels with pin_oe=0 stay at 0 (high impedance).
- R7: The hold and state registers do not update while frozen. After exit, the outputs resume from the held values before new input reaches them.
- R8: standby falls on the second clock edge after the request goes inactive. The next edge captures the pins again.
- R9: With keep_en=1, a channel whose din_drv bit is 0 reads the last level it had while driven. With keep_en=0, it reads din directly. The remembered level survives a period with keep_en=0.
- R10: The keeper's remembered level is not updated by levels driven during standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_en | input | 1 | Static enable for the pin-controlled power-down |
| keep_en | input | 1 | Static enable for the keeper on undriven inputs |
| pd_a | input | 1 | Asynchronous power-down pin A |
| pd_b | input | 1 | Asynchronous power-down pin B |
| din | input | W | Channel input pin levels |
| din_drv | input | W | 1 where the input pin is actively driven |
| oe_req | input | W | Requested output enable per channel |
| out_sel | input | W | Per-channel view select: 1 registered, 0 change-detect |
| pin_out | output | W | Channel output levels |
| pin_oe | output | W | Channel output enables (0 = high impedance) |
| standby | output | 1 | Block is frozen |

## Verification
Each result has a fixed latency in edges. The registered output lands two edges after the input changes. The change-detect view moves after one edge and settles after two. The output enable lands after one edge. standby rises or falls on the second edge after a power-down pin toggles. The bench drives every input just after a falling edge and samples half a period after the edge it counts to. It checks each latency at the edge before as well as at the edge itself, so a result that arrives one edge early or late is caught. During a freeze, the checks are repeated over several edges while the inputs keep changing.

// File: rtl/pdh_pkg.sv
`timescale 1ns/1ps
package pdh_pkg;
   typedef enum logic {
      VIEW_CHANGE = 1'b0,
      VIEW_STATE  = 1'b1
   } view_e;

   localparam int unsigned PDH_MIN_STAGES = 2;
   localparam int unsigned PDH_MAX_STAGES = 8;
endpackage

// File: rtl/pdh_sync.sv
`timescale 1ns/1ps
module pdh_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pdh_keeper.sv
`timescale 1ns/1ps
module pdh_keeper #(
   parameter int unsigned W         = 8,
   parameter bit          KEEPER_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         freeze,
   input  logic         keep_en,
   input  logic [W-1:0] din,
   input  logic [W-1:0] din_drv,
   output logic [W-1:0] eff_in,
   output logic [W-1:0] kept_lvl
);
   generate
      if (KEEPER_EN) begin : g_keep
         for (genvar i = 0; i < W; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  kept_lvl[i] <= 1'b0;
               else if (!freeze && din_drv[i])
                  kept_lvl[i] <= din[i];
            end
            assign eff_in[i] = (keep_en && !din_drv[i]) ? kept_lvl[i] : din[i];
         end
      end else begin : g_pass
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, freeze, keep_en, din_drv};
         assign kept_lvl  = '0;
         assign eff_in    = din;
      end
   endgenerate
endmodule

// File: rtl/pdh_hold_core.sv
`timescale 1ns/1ps
module pdh_hold_core
   import pdh_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         freeze,
   input  logic [W-1:0] eff_in,
   input  logic [W-1:0] oe_req,
   input  logic [W-1:0] out_sel,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe
);
   logic [W-1:0] in_hold;
   logic [W-1:0] st_q;
   logic [W-1:0] oe_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_hold <= '0;
         st_q    <= '0;
         oe_hold <= '0;
      end else if (!freeze) begin
         in_hold <= eff_in;
         st_q    <= in_hold;
         oe_hold <= oe_req;
      end
   end

   generate
      for (genvar i = 0; i < W; i++) begin : g_view
         always_comb begin
            if (view_e'(out_sel[i]) == VIEW_STATE) pin_out[i] = st_q[i];
            else                                   pin_out[i] = in_hold[i] ^ st_q[i];
         end
      end
   endgenerate

   assign pin_oe = oe_hold;
endmodule

// File: rtl/pdh_freeze_unit.sv
`timescale 1ns/1ps
module pdh_freeze_unit
   import pdh_pkg::*;
#(
   parameter int unsigned W           = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          KEEPER_EN   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pd_en,
   input  logic         keep_en,
   input  logic         pd_a,
   input  logic         pd_b,
   input  logic [W-1:0] din,
   input  logic [W-1:0] din_drv,
   input  logic [W-1:0] oe_req,
   input  logic [W-1:0] out_sel,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe,
   output logic         standby
);
   generate
      if (W < 1) begin : g_bad_w
         $error("pdh_freeze_unit: W must be at least 1");
      end
      if (SYNC_STAGES < PDH_MIN_STAGES || SYNC_STAGES > PDH_MAX_STAGES) begin : g_bad_s
         $error("pdh_freeze_unit: SYNC_STAGES out of range");
      end
   endgenerate

   logic         pd_req_raw;
   logic         frozen;
   logic [W-1:0] eff_in;
   logic [W-1:0] kept_lvl;

   assign pd_req_raw = pd_en & (pd_a | pd_b);

   pdh_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pd_req_raw),
      .sync_out (frozen)
   );

   pdh_keeper #(.W(W), .KEEPER_EN(KEEPER_EN)) u_keep (
      .clk      (clk),
      .rst_n    (rst_n),
      .freeze   (frozen),
      .keep_en  (keep_en),
      .din      (din),
      .din_drv  (din_drv),
      .eff_in   (eff_in),
      .kept_lvl (kept_lvl)
   );

   pdh_hold_core #(.W(W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .freeze  (frozen),
      .eff_in  (eff_in),
      .oe_req  (oe_req),
      .out_sel (out_sel),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );

   assign standby = frozen;
endmodule

// File: rtl/pdh_freeze_chk.sv
`timescale 1ns/1ps
module pdh_freeze_chk #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input logic         clk,
   input logic         rst_n,
   input logic         pd_en,
   input logic         pd_a,
   input logic         pd_b,
   input logic [W-1:0] pin_out,
   input logic [W-1:0] pin_oe,
   input logic [W-1:0] kept_lvl,
   input logic         standby
);
   logic       req;
   logic [7:0] run_hi;
   logic [7:0] run_lo;

   assign req = pd_en & (pd_a | pd_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_hi <= '0;
         run_lo <= '0;
      end else begin
         run_hi <= !req ? 8'd0 : (run_hi < 8'(STAGES) ? run_hi + 8'd1 : run_hi);
         run_lo <=  req ? 8'd0 : (run_lo < 8'(STAGES) ? run_lo + 8'd1 : run_lo);
      end
   end

   // R1: reset leaves outputs idle
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |-> (pin_oe == '0 && pin_out == '0 && !standby));

   // R4: a request held for the sync depth has frozen the block
   a_r4_enter: assert property (@(posedge clk) disable iff (!rst_n)
      run_hi >= 8'(STAGES) |-> standby);

   // R8: a request absent for the sync depth has released the block
   a_r8_exit: assert property (@(posedge clk) disable iff (!rst_n)
      run_lo >= 8'(STAGES) |-> !standby);

   // R6: outputs and enables do not move across an edge taken in standby
   a_r6_hold_pins: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> ($stable(pin_out) && $stable(pin_oe)));

   // R10: remembered keeper levels are not rewritten in standby
   a_r10_keep_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> $stable(kept_lvl));
endmodule

bind pdh_freeze_unit pdh_freeze_chk #(.W(W), .STAGES(SYNC_STAGES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pd_en    (pd_en),
   .pd_a     (pd_a),
   .pd_b     (pd_b),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .kept_lvl (kept_lvl),
   .standby  (standby)
);

// File: tb/pdh_freeze_unit_test.sv
`timescale 1ns/1ps
module pdh_freeze_unit_test;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pd_en = 1'b0, keep_en = 1'b0, pd_a = 1'b0, pd_b = 1'b0;
   logic [W-1:0] din = '0, din_drv = '1, oe_req = '0, out_sel = '1;
   logic [W-1:0] pin_out, pin_oe;
   logic         standby;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pdh_freeze_unit #(.W(W), .SYNC_STAGES(2), .KEEPER_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .pd_en(pd_en), .keep_en(keep_en),
      .pd_a(pd_a), .pd_b(pd_b), .din(din), .din_drv(din_drv),
      .oe_req(oe_req), .out_sel(out_sel),
      .pin_out(pin_out), .pin_oe(pin_oe), .standby(standby)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic t_reset;
      step(1);
      chk("R1 pin_out", pin_out, '0);
      chk("R1 pin_oe", pin_oe, '0);
      chk("R1 standby", {7'd0, standby}, 8'd0);
      rst_n = 1'b1;
      step(0);
      chk("R1 after release", pin_out, '0);
   endtask

   task automatic t_datapath;
      out_sel = '1; din = 8'hA5;
      step(1);
      chk("R2 reg view one edge", pin_out, 8'h00);
      step(1);
      chk("R2 reg view two edges", pin_out, 8'hA5);
      out_sel = '0;
      step(0);
      chk("R2 change view steady", pin_out, 8'h00);
      din = 8'h3C;
      step(1);
      chk("R2 change view one edge", pin_out, 8'h99);
      step(1);
      chk("R2 change view settled", pin_out, 8'h00);
      out_sel = '1;
   endtask

   task automatic t_oe;
      oe_req = 8'hF0;
      step(0);
      chk("R3 oe before edge", pin_oe, 8'h00);
      step(1);
      chk("R3 oe one edge", pin_oe, 8'hF0);
   endtask

   task automatic t_disabled;
      pd_en = 1'b0; pd_a = 1'b1; pd_b = 1'b1; din = 8'h11;
      step(4);
      chk("R5 standby low", {7'd0, standby}, 8'd0);
      chk("R5 data flows", pin_out, 8'h11);
      pd_a = 1'b0; pd_b = 1'b0;
   endtask

   task automatic t_freeze;
      pd_en = 1'b1; din = 8'h5A; oe_req = 8'h0F;
      step(3);
      pd_b = 1'b1;
      step(1);
      chk("R4 not yet after one edge", {7'd0, standby}, 8'd0);
      step(1);
      chk("R4 standby after two edges", {7'd0, standby}, 8'd1);
      din = 8'hFF; oe_req = 8'hFF; din_drv = 8'h0F;
      for (int k = 0; k < 4; k++) begin
         step(1);
         chk("R6 pin_out held", pin_out, 8'h5A);
         chk("R6 pin_oe held, hi-Z kept", pin_oe, 8'h0F);
         din = ~din; oe_req = ~oe_req; din_drv = ~din_drv;
      end
      out_sel = '0;
      step(0);
      chk("R7 state unchanged in change view", pin_out, 8'h00);
      out_sel = '1; din = 8'hFF; oe_req = 8'hFF; din_drv = '1;
      step(1);
   endtask

   task automatic t_resume;
      pd_b = 1'b0;
      step(1);
      chk("R8 still frozen after one edge", {7'd0, standby}, 8'd1);
      step(1);
      chk("R8 released after two edges", {7'd0, standby}, 8'd0);
      chk("R7 resumes from held value", pin_out, 8'h5A);
      step(1);
      chk("R8 oe captured again", pin_oe, 8'hFF);
      chk("R7 held state shifts first", pin_out, 8'h5A);
      step(1);
      chk("R8 new data arrives", pin_out, 8'hFF);
   endtask

   task automatic t_keeper;
      pd_en = 1'b0; keep_en = 1'b1; din_drv = '1; din = 8'h01;
      step(2);
      chk("R9 driven level", pin_out, 8'h01);
      din_drv = 8'hFE; din = 8'h00;
      step(2);
      chk("R9 undriven bit kept", pin_out, 8'h01);
      keep_en = 1'b0;
      step(2);
      chk("R9 keeper off reads pin", pin_out, 8'h00);
      keep_en = 1'b1;
      step(2);
      chk("R9 kept level survives", pin_out, 8'h01);
   endtask

   task automatic t_keeper_freeze;
      din_drv = '1; din = 8'h01;
      step(2);
      pd_en = 1'b1; pd_a = 1'b1;
      step(2);
      chk("R4 pin A freezes", {7'd0, standby}, 8'd1);
      din = 8'h00;
      step(3);
      chk("R6 frozen output", pin_out, 8'h01);
      din_drv = 8'hFE;
      pd_a = 1'b0;
      step(2);
      chk("R8 exit via pin A", {7'd0, standby}, 8'd0);
      step(2);
      chk("R10 keeper ignored frozen drive", pin_out, 8'h01);
   endtask

   initial begin
      t_reset();
      t_datapath();
      t_oe();
      t_disabled();
      t_freeze();
      t_resume();
      t_keeper();
      t_keeper_freeze();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule